// File: doc/BRIEF.md
# Configurable-Width Decrementer Timer

This block is a down-counting timer register that raises a timer interrupt. Software loads it through a write port. Each cycle in which the timebase tick enable is high, it counts down by one. When the count crosses from non-negative to negative, or when certain values are written, the interrupt output is raised. A run-time mode input selects the active width. In normal mode the active width is 32 bits. In large mode it is the `LARGE_W` parameter, which must be greater than 32.

Every value the register holds is sign-extended from the top bit of the active width. A second parameter, `LEVEL_SIG`, chooses how underflow is signalled:

- **Triggered-only style:** an interrupt, once raised, stays pending until it is acknowledged.
- **Triggered-plus-level style:** the interrupt follows the sign of the count, and a non-negative write withdraws it.

Top module: `dec_timer`

## Requirements
- R1: A write keeps the low N bits of `wr_data` (N = 32 when `large_en` is 0, N = `LARGE_W` when it is 1) and sign-extends bit N-1 into the whole register.
- R2: On each cycle with `tick` high and no write, the register decreases by one. Without `tick` it holds its value.
- R3: With `large_en` = 1, `rd_data` shows the whole sign-extended register. With `large_en` = 0, it shows only bits 31:0, with the upper bits zero.
- R4: A write whose extended value, taken as unsigned, is 0, 1 or 2 sets `irq` on the next cycle in both signalling styles.
- R5: A tick that changes bit N-1 from 0 to 1 sets `irq`. In large mode, a change of bit 31 alone raises nothing.
- R6: In level style, `ack` does not clear `irq` while bit N-1 is set, and it does clear `irq` when that bit is clear. In triggered-only style, `ack` clears `irq` (a raise in the same cycle wins).
- R7: In level style, a write of a non-negative value of 3 or more clears `irq`. In triggered-only style, such a write leaves `irq` unchanged.
- R8: After reset the register holds 0xFFFFFFFF sign-extended from 32 bits (all ones) and `irq` is 0.
- R9: A negative write (bit N-1 set) always raises `irq` in level style. In triggered-only style, it raises `irq` only when bit N-1 of the previous value was clear.
- R10: When `wr_en` and `tick` are high in the same cycle, the written value is loaded and the tick is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timebase tick enable, one count per high cycle |
| large_en | input | 1 | 1 selects large width `LARGE_W`, 0 selects 32 bits |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | LARGE_W | Write value, truncated to the active width |
| ack | input | 1 | Interrupt acknowledge |
| rd_data | output | LARGE_W | Register read value, formatted per mode |
| irq | output | 1 | Registered decrementer interrupt |

## Verification
Two instances, one per signalling style, receive the same directed stimulus, so each step shows where the styles diverge:

- **Acknowledge and write rules:** acknowledges while the sign bit is set, non-negative writes over a pending interrupt, and a second negative write onto an already-negative value.
- **Width-dependent checks:** written values carry bit 31 set with the top bit clear, and the reverse, so truncation and extension at each width are visible through both read formats.
- **Count and priority checks:** counting runs across zero and across bit 31 in large mode, and a write coincides with a tick.

// File: rtl/dec_timer_pkg.sv
package dec_timer_pkg;
  localparam int unsigned BASE_W = 32;
  localparam int unsigned SMALL_LIMIT = 3;
endpackage

// File: rtl/dec_sext.sv
module dec_sext
  import dec_timer_pkg::*;
#(
  parameter int unsigned W = 56
) (
  input  logic         large_en,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         neg
);
  localparam int unsigned EXT_W = W - BASE_W;

  always_comb begin
    if (large_en) begin
      dout = din;
      neg  = din[W-1];
    end else begin
      dout = {{EXT_W{din[BASE_W-1]}}, din[BASE_W-1:0]};
      neg  = din[BASE_W-1];
    end
  end
endmodule

// File: rtl/dec_irq_ctl.sv
module dec_irq_ctl #(
  parameter bit LEVEL_SIG = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic wr_en,
  input  logic tick,
  input  logic ack,
  input  logic wr_small,
  input  logic wr_neg,
  input  logic old_neg,
  input  logic dec_neg,
  output logic irq
);
  logic raise_wr, raise_tick, lower_wr, hold, ack_clr;

  generate
    if (LEVEL_SIG) begin : g_level
      assign raise_wr = wr_small | wr_neg;
      assign lower_wr = ~wr_neg & ~wr_small;
      assign hold     = old_neg;
    end else begin : g_trig
      assign raise_wr = wr_small | (wr_neg & ~old_neg);
      assign lower_wr = 1'b0;
      assign hold     = 1'b0;
    end
  endgenerate

  assign raise_tick = tick & ~old_neg & dec_neg;
  assign ack_clr    = ack & ~hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq <= 1'b0;
    end else if (wr_en) begin
      if (raise_wr)      irq <= 1'b1;
      else if (lower_wr) irq <= 1'b0;
      else if (ack_clr)  irq <= 1'b0;
    end else begin
      if (raise_tick)    irq <= 1'b1;
      else if (ack_clr)  irq <= 1'b0;
    end
  end
endmodule

// File: rtl/dec_timer.sv
module dec_timer
  import dec_timer_pkg::*;
#(
  parameter int unsigned LARGE_W   = 56,
  parameter bit          LEVEL_SIG = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic               large_en,
  input  logic               wr_en,
  input  logic [LARGE_W-1:0] wr_data,
  input  logic               ack,
  output logic [LARGE_W-1:0] rd_data,
  output logic               irq
);
  localparam int unsigned HI_W = LARGE_W - BASE_W;

  logic [LARGE_W-1:0] cnt_q, cnt_dec, wr_ext;
  logic               wr_neg, old_neg, dec_neg, wr_small;

  dec_sext #(.W(LARGE_W)) u_wr_ext (
    .large_en (large_en),
    .din      (wr_data),
    .dout     (wr_ext),
    .neg      (wr_neg)
  );

  assign cnt_dec  = cnt_q - LARGE_W'(1);
  assign old_neg  = large_en ? cnt_q[LARGE_W-1]   : cnt_q[BASE_W-1];
  assign dec_neg  = large_en ? cnt_dec[LARGE_W-1] : cnt_dec[BASE_W-1];
  assign wr_small = wr_ext < LARGE_W'(SMALL_LIMIT);

  always_ff @(posedge clk) begin
    if (rst)         cnt_q <= '1;
    else if (wr_en)  cnt_q <= wr_ext;
    else if (tick)   cnt_q <= cnt_dec;
  end

  assign rd_data = large_en ? cnt_q : {{HI_W{1'b0}}, cnt_q[BASE_W-1:0]};

  dec_irq_ctl #(.LEVEL_SIG(LEVEL_SIG)) u_irq (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .tick     (tick),
    .ack      (ack),
    .wr_small (wr_small),
    .wr_neg   (wr_neg),
    .old_neg  (old_neg),
    .dec_neg  (dec_neg),
    .irq      (irq)
  );
endmodule

// File: rtl/dec_timer_chk.sv
module dec_timer_chk #(
  parameter int unsigned LARGE_W   = 56,
  parameter bit          LEVEL_SIG = 1'b1
) (
  input logic               clk,
  input logic               rst,
  input logic               tick,
  input logic               large_en,
  input logic               wr_en,
  input logic [LARGE_W-1:0] wr_data,
  input logic               ack,
  input logic [LARGE_W-1:0] rd_data,
  input logic               irq
);
  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  // R8: state right after reset
  always_ff @(posedge clk) begin
    if (rst_q && !rst && !large_en)
      a_r8_reset_value: assert (rd_data[31:0] == 32'hFFFF_FFFF && !irq);
  end

  a_r4_small_write: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !large_en && wr_data[31:0] < 32'd3) |=> irq);

  a_r10_write_wins: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !large_en) |=> (large_en || rd_data[31:0] == $past(wr_data[31:0])));

  a_r2_count_down: assert property (@(posedge clk) disable iff (rst)
    (tick && !wr_en && !large_en && rd_data != '0) |=>
      (large_en || rd_data == $past(rd_data) - LARGE_W'(1)));

  a_r5_underflow: assert property (@(posedge clk) disable iff (rst)
    (tick && !wr_en && !large_en && rd_data == '0) |=>
      (irq && (large_en || rd_data == LARGE_W'(32'hFFFF_FFFF))));

  a_r6_level_hold: assert property (@(posedge clk) disable iff (rst)
    (LEVEL_SIG && irq && !wr_en && !large_en && rd_data[31]) |=> irq);

  a_r6_trig_ack: assert property (@(posedge clk) disable iff (rst)
    (!LEVEL_SIG && ack && !wr_en && !tick) |=> !irq);
endmodule

bind dec_timer dec_timer_chk #(.LARGE_W(LARGE_W), .LEVEL_SIG(LEVEL_SIG)) u_chk (.*);

// File: tb/dec_timer_tb.sv
module dec_timer_tb;
  localparam int unsigned W = 56;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         tick = 1'b0, large_en = 1'b0, wr_en = 1'b0, ack = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] rd_lvl, rd_trg;
  logic         irq_lvl, irq_trg;
  int           n_checks = 0, n_errors = 0;

  always #10 clk = ~clk;

  dec_timer #(.LARGE_W(W), .LEVEL_SIG(1'b1)) u_dut (
    .clk(clk), .rst(rst), .tick(tick), .large_en(large_en), .wr_en(wr_en),
    .wr_data(wr_data), .ack(ack), .rd_data(rd_lvl), .irq(irq_lvl));

  dec_timer #(.LARGE_W(W), .LEVEL_SIG(1'b0)) u_dut_trg (
    .clk(clk), .rst(rst), .tick(tick), .large_en(large_en), .wr_en(wr_en),
    .wr_data(wr_data), .ack(ack), .rd_data(rd_trg), .irq(irq_trg));

  task automatic check(input string req, input logic [W-1:0] rd_exp,
                       input logic lvl_exp, input logic trg_exp);
    n_checks++;
    if (rd_lvl !== rd_exp || rd_trg !== rd_exp) begin
      n_errors++;
      $display("FAIL %s rd: level=%h trig=%h expected=%h", req, rd_lvl, rd_trg, rd_exp);
    end
    n_checks++;
    if (irq_lvl !== lvl_exp) begin
      n_errors++;
      $display("FAIL %s irq level-style: actual=%b expected=%b", req, irq_lvl, lvl_exp);
    end
    n_checks++;
    if (irq_trg !== trg_exp) begin
      n_errors++;
      $display("FAIL %s irq trig-style: actual=%b expected=%b", req, irq_trg, trg_exp);
    end
  endtask

  task automatic do_write(input logic [W-1:0] v);
    wr_en = 1'b1; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_tick(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
    end
    tick = 1'b0;
  endtask

  task automatic do_ack();
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
  endtask

  task automatic set_mode(input logic l);
    large_en = l;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  task automatic t_reset();
    check("R8 reset normal read", 56'h00_0000_FFFF_FFFF, 1'b0, 1'b0);
    set_mode(1'b1);
    check("R8 R3 reset large read", 56'hFF_FFFF_FFFF_FFFF, 1'b0, 1'b0);
    set_mode(1'b0);
  endtask

  task automatic t_count();
    do_write(56'd10);
    check("R2 load", 56'd10, 1'b0, 1'b0);
    do_tick(3);
    check("R2 three ticks", 56'd7, 1'b0, 1'b0);
    @(negedge clk);
    check("R2 idle holds", 56'd7, 1'b0, 1'b0);
  endtask

  task automatic t_small_and_underflow();
    do_write(56'd2);
    check("R4 write 2", 56'd2, 1'b1, 1'b1);
    do_ack();
    check("R6 ack with sign clear", 56'd2, 1'b0, 1'b0);
    do_tick(2);
    check("R5 reach zero", 56'd0, 1'b0, 1'b0);
    do_tick(1);
    check("R5 underflow raise", 56'h00_0000_FFFF_FFFF, 1'b1, 1'b1);
    do_write(56'd100);
    check("R7 non-negative write", 56'd100, 1'b0, 1'b1);
    do_ack();
    check("R6 trig ack", 56'd100, 1'b0, 1'b0);
  endtask

  task automatic t_negative_writes();
    do_write(56'h00_0000_8000_0000);
    check("R9 negative from positive", 56'h00_0000_8000_0000, 1'b1, 1'b1);
    do_ack();
    check("R6 ack while negative", 56'h00_0000_8000_0000, 1'b1, 1'b0);
    do_write(56'h00_0000_9000_0000);
    check("R9 negative onto negative", 56'h00_0000_9000_0000, 1'b1, 1'b0);
  endtask

  task automatic t_widths();
    set_mode(1'b1);
    check("R1 R3 large view of normal write", 56'hFF_FFFF_9000_0000, 1'b1, 1'b0);
    do_write(56'h00_0000_8000_0000);
    check("R1 bit31 positive in large", 56'h00_0000_8000_0000, 1'b0, 1'b0);
    do_write(56'h80_0000_0000_0000);
    check("R9 large negative", 56'h80_0000_0000_0000, 1'b1, 1'b1);
    do_ack();
    check("R6 large ack", 56'h80_0000_0000_0000, 1'b1, 1'b0);
    set_mode(1'b0);
    do_write(56'hAB_CDEF_8000_0001);
    check("R1 R3 truncated normal read", 56'h00_0000_8000_0001, 1'b1, 1'b1);
    set_mode(1'b1);
    check("R1 sign-extended large read", 56'hFF_FFFF_8000_0001, 1'b1, 1'b1);
  endtask

  task automatic t_large_count();
    do_write(56'h00_0001_0000_0000);
    check("R7 large positive write", 56'h00_0001_0000_0000, 1'b0, 1'b1);
    do_ack();
    do_tick(1);
    check("R5 bit31 crossing in large", 56'h00_0000_FFFF_FFFF, 1'b0, 1'b0);
    tick = 1'b1;
    do_write(56'd5);
    tick = 1'b0;
    check("R10 write beats tick", 56'd5, 1'b0, 1'b0);
    do_tick(5);
    check("R2 large to zero", 56'd0, 1'b0, 1'b0);
    do_tick(1);
    check("R5 large underflow", 56'hFF_FFFF_FFFF_FFFF, 1'b1, 1'b1);
    do_ack();
    check("R6 ack after large underflow", 56'hFF_FFFF_FFFF_FFFF, 1'b1, 1'b0);
    do_write(56'd1);
    check("R4 large write 1", 56'd1, 1'b1, 1'b1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_count();
    t_small_and_underflow();
    t_negative_writes();
    t_widths();
    t_large_count();
    summary();
  end
endmodule